// File: doc/BRIEF.md
# Sleep-Mode Bus and Local Wake Detector

This block runs in a bus transceiver's low-power state and decides when the node must wake up. It watches two comparator flags from the bus input, the local wake pin and a 1 µs time base. It filters each source against short disturbances and raises one wake request, tagged with where it came from. The flags are: the bus has fallen below the pre-wake level, and the bus is dominant. The mode controller uses the request to leave sleep, and uses the source tag to report a local or a remote wake.

A remote wake needs the bus to fall, stay dominant for longer than the bus filter time, and then rise again. While the block looks for that sequence it asserts a receiver-active output, and it does so only for a bounded monitoring window. The window can end on a bus that floats between thresholds, or on a bus that is held dominant, as by a short to ground. If the bus floated, the bus must first return fully recessive before a new detection can start. If the bus was held dominant, the next release of the bus wakes the node at once. A local wake needs the wake pin to be held low for longer than its filter time, and only after the pin has been high for a re-arm period. This means a pin that is stuck low never wakes the node again.

All level inputs pass through a synchroniser first. Filter times count ticks of `tick_i`. The request is a one-cycle pulse. Once a request has been given, the block stays quiet until the mode controller leaves sleep.

Top module: `wake_detect`

## Requirements
- R1: After reset, `wake_req_o`, `wake_local_o` and `rx_active_o` are all 0.
- R2: While `sleep_i` is 1, setting `bus_pre_i` to 1 drives `rx_active_o` to 1 within 4 clock cycles. It stays 1 for the monitoring window.
- R3: In sleep, with `bus_pre_i` at 1, suppose `bus_dom_i` is held at 1 for more than `BUS_FILT_US` ticks and then returns to 0. This gives exactly one request with `wake_local_o` = 0 (0 means remote). A dominant period shorter than `BUS_FILT_US` ticks gives no request.
- R4: Suppose no remote wake occurs within `MON_US` ticks of the receiver turning on, and the bus is not dominant at that moment (floating). Then `rx_active_o` returns to 0 and no request is given.
- R5: After a floating timeout, a full dominant-then-release sequence gives no request while `bus_pre_i` stays 1. Once `bus_pre_i` has been 0, a new sequence wakes as in R3.
- R6: Suppose the bus is still dominant when the `MON_US` window ends. Then `rx_active_o` returns to 0 with no request. The next 1-to-0 change of `bus_dom_i` gives a remote request within 8 cycles, with no filter.
- R7: In sleep, with the block armed, holding `wake_pin_i` low for more than `WAKE_FILT_US` ticks gives exactly one request with `wake_local_o` = 1 (1 means local). A shorter low gives none.
- R8: The local path arms only after `wake_pin_i` has been high for `REARM_US` ticks. A pin that is already low when sleep begins, or that is high for less than `REARM_US` ticks, gives no local request however long it then stays low.
- R9: `wake_req_o` is high for a single cycle. After a request, no further request is given until `sleep_i` has been 0.
- R10: One cycle after `sleep_i` is 0, `wake_req_o`, `wake_local_o` and `rx_active_o` are 0. No bus or pin activity gives a request while `sleep_i` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | 1 while the node is in sleep mode |
| tick_i | input | 1 | One-cycle pulse every microsecond |
| bus_pre_i | input | 1 | Bus is below the pre-wake level (asynchronous) |
| bus_dom_i | input | 1 | Bus is dominant (asynchronous) |
| wake_pin_i | input | 1 | Local wake pin level, low is active (asynchronous) |
| wake_req_o | output | 1 | One-cycle wake request |
| wake_local_o | output | 1 | Source of the last request: 1 local, 0 remote; cleared outside sleep |
| rx_active_o | output | 1 | Keeps the bus receiver powered during the monitoring window |

## Verification
Each kind of wrong internal state shows up at the ports in its own way:
- A detection state stuck in the monitoring phase shows as `rx_active_o` still high one window after the bus stopped moving.
- A lost lockout or short-circuit state shows as a request that comes too early, or never comes, within a few cycles of the bus being released.
- A bad filter count shifts the dominant or low duration that first gives a request. The bench therefore probes durations a few ticks on either side of each filter time.
- A re-arm fault shows as a wake from a pin that was already low.
- A missing clear on wake shows as a second pulse, or as a source tag that lingers into the cycle after sleep ends.

// File: rtl/wake_detect.sv
module wake_detect #(
  parameter int BUS_FILT_US  = 90,
  parameter int WAKE_FILT_US = 35,
  parameter int MON_US       = 10000,
  parameter int REARM_US     = 6,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  input  logic tick_i,
  input  logic bus_pre_i,
  input  logic bus_dom_i,
  input  logic wake_pin_i,
  output logic wake_req_o,
  output logic wake_local_o,
  output logic rx_active_o
);
  localparam int DW = $clog2(BUS_FILT_US + 1);
  localparam int MW = $clog2(MON_US + 1);
  localparam int LW = $clog2(WAKE_FILT_US + 1);
  localparam int HW = $clog2(REARM_US + 1);
  localparam logic [DW-1:0] DOM_LAST = DW'(BUS_FILT_US - 1);
  localparam logic [MW-1:0] MON_LAST = MW'(MON_US - 1);
  localparam logic [LW-1:0] LOW_LAST = LW'(WAKE_FILT_US - 1);
  localparam logic [HW-1:0] HIGH_END = HW'(REARM_US);

  typedef enum logic [1:0] {B_IDLE, B_MON, B_SHORT, B_LOCK} bus_st_t;

  logic [SYNC_STAGES-1:0] pre_sh, dom_sh, pin_sh;
  logic pre_s, dom_s, pin_s, dom_q;
  bus_st_t bst;
  logic [MW-1:0] mon_cnt;
  logic [DW-1:0] dom_cnt;
  logic dom_ok;
  logic [LW-1:0] low_cnt;
  logic [HW-1:0] high_cnt;
  logic armed, woke;
  logic listen, dom_fall, fire_r, fire_l, mon_end;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_sh <= '0;
      dom_sh <= '0;
      pin_sh <= '1;
      dom_q  <= 1'b0;
    end else begin
      pre_sh <= {pre_sh[SYNC_STAGES-2:0], bus_pre_i};
      dom_sh <= {dom_sh[SYNC_STAGES-2:0], bus_dom_i};
      pin_sh <= {pin_sh[SYNC_STAGES-2:0], wake_pin_i};
      dom_q  <= dom_sh[SYNC_STAGES-1];
    end

  assign pre_s    = pre_sh[SYNC_STAGES-1];
  assign dom_s    = dom_sh[SYNC_STAGES-1];
  assign pin_s    = pin_sh[SYNC_STAGES-1];
  assign listen   = sleep_i & ~woke;
  assign dom_fall = dom_q & ~dom_s;
  assign mon_end  = tick_i & (mon_cnt == MON_LAST);
  assign fire_r   = listen & dom_fall & (((bst == B_MON) & dom_ok) | (bst == B_SHORT));
  assign fire_l   = listen & armed & ~pin_s & tick_i & (low_cnt == LOW_LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bst     <= B_IDLE;
      mon_cnt <= '0;
      dom_cnt <= '0;
      dom_ok  <= 1'b0;
    end else if (!listen || fire_r || fire_l) begin
      bst     <= B_IDLE;
      mon_cnt <= '0;
      dom_cnt <= '0;
      dom_ok  <= 1'b0;
    end else begin
      case (bst)
        B_IDLE: begin
          mon_cnt <= '0;
          dom_cnt <= '0;
          dom_ok  <= 1'b0;
          if (pre_s) bst <= B_MON;
        end
        B_MON: begin
          if (mon_end) begin
            bst    <= dom_s ? B_SHORT : B_LOCK;
            dom_ok <= 1'b0;
          end else if (!pre_s && !dom_s) begin
            bst <= B_IDLE;
          end else begin
            if (tick_i) mon_cnt <= mon_cnt + 1'b1;
            if (!dom_s) begin
              dom_cnt <= '0;
              dom_ok  <= 1'b0;
            end else if (tick_i && !dom_ok) begin
              dom_cnt <= dom_cnt + 1'b1;
              if (dom_cnt == DOM_LAST) dom_ok <= 1'b1;
            end
          end
        end
        B_SHORT: ;
        B_LOCK: if (!pre_s) bst <= B_IDLE;
        default: bst <= B_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      high_cnt <= '0;
      armed    <= 1'b0;
      low_cnt  <= '0;
    end else begin
      if (!pin_s) high_cnt <= '0;
      else if (tick_i && high_cnt != HIGH_END) high_cnt <= high_cnt + 1'b1;

      if (fire_l || (!pin_s && !listen)) armed <= 1'b0;
      else if (pin_s && high_cnt == HIGH_END) armed <= 1'b1;

      if (armed && !pin_s && listen && !fire_l) begin
        if (tick_i) low_cnt <= low_cnt + 1'b1;
      end else begin
        low_cnt <= '0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      woke         <= 1'b0;
      wake_req_o   <= 1'b0;
      wake_local_o <= 1'b0;
    end else begin
      wake_req_o <= fire_r | fire_l;
      if (!sleep_i) begin
        woke         <= 1'b0;
        wake_local_o <= 1'b0;
      end else if (fire_r || fire_l) begin
        woke         <= 1'b1;
        wake_local_o <= fire_l;
      end
    end

  assign rx_active_o = (bst == B_MON);
endmodule

// File: rtl/wake_detect_chk.sv
module wake_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep_i,
  input logic wake_req_o,
  input logic wake_local_o,
  input logic rx_active_o
);
  logic seen;
  logic past_valid;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      seen       <= 1'b0;
      past_valid <= 1'b0;
    end else begin
      past_valid <= 1'b1;
      if (!sleep_i) seen <= 1'b0;
      else if (wake_req_o) seen <= 1'b1;
    end

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o |=> !wake_req_o);

  p_one_per_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> !wake_req_o);

  p_no_req_awake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && !$past(sleep_i)) |-> !wake_req_o);

  p_rx_off_awake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && !$past(sleep_i)) |-> !rx_active_o);

  p_src_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && !$past(sleep_i)) |-> !wake_local_o);

  p_rx_off_after_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o |=> !rx_active_o);
endmodule

bind wake_detect wake_detect_chk chk (.*);

// File: tb/wake_detect_test.sv
module wake_detect_test;
  localparam int BF = 20;
  localparam int WF = 10;
  localparam int MON = 300;
  localparam int RA = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_i = 1'b0, tick_i = 1'b0, bus_pre_i = 1'b0, bus_dom_i = 1'b0, wake_pin_i = 1'b1;
  logic wake_req_o, wake_local_o, rx_active_o;

  int total = 0, bad = 0;
  int pulses = 0, doubles = 0;
  logic last_src = 1'b0, prev_req = 1'b0;
  bit done = 1'b0;
  int tdiv = 0;

  wake_detect #(.BUS_FILT_US(BF), .WAKE_FILT_US(WF), .MON_US(MON), .REARM_US(RA)) uut (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .tick_i(tick_i),
    .bus_pre_i(bus_pre_i), .bus_dom_i(bus_dom_i), .wake_pin_i(wake_pin_i),
    .wake_req_o(wake_req_o), .wake_local_o(wake_local_o), .rx_active_o(rx_active_o));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= (tdiv + 1) % 2;
    tick_i <= (tdiv == 1);
    prev_req <= wake_req_o;
    if (wake_req_o) begin
      pulses <= pulses + 1;
      last_src <= wake_local_o;
      if (prev_req) doubles <= doubles + 1;
    end
  end

  function automatic int exp_wake(int dur, int filt);
    return (dur > filt) ? 1 : 0;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_sleep();
    sleep_i = 1'b0;
    cyc(10);
    sleep_i = 1'b1;
    cyc(4);
  endtask

  task automatic remote(int ticks);
    bus_pre_i = 1'b1;
    cyc(6);
    bus_dom_i = 1'b1;
    cyc(2 * ticks);
    bus_dom_i = 1'b0;
    bus_pre_i = 1'b0;
    cyc(10);
  endtask

  task automatic local_low(int ticks);
    wake_pin_i = 1'b0;
    cyc(2 * ticks);
    wake_pin_i = 1'b1;
    cyc(2 * (RA + 3));
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      report();
    end
  end

  initial begin
    int base;
    void'($urandom(77));
    cyc(3);
    check("R1 req", int'(wake_req_o), 0);
    check("R1 src", int'(wake_local_o), 0);
    check("R1 rx", int'(rx_active_o), 0);
    rst_n = 1'b1;
    cyc(2 * (RA + 4));

    enter_sleep();
    base = pulses;
    bus_pre_i = 1'b1;
    cyc(6);
    check("R2 rx on", int'(rx_active_o), 1);
    bus_dom_i = 1'b1; cyc(2 * (BF - 5)); bus_dom_i = 1'b0; cyc(10);
    check("R3 short dominant", pulses - base, 0);
    check("R2 rx held", int'(rx_active_o), 1);
    bus_dom_i = 1'b1; cyc(2 * (BF + 5)); bus_dom_i = 1'b0; bus_pre_i = 1'b0; cyc(10);
    check("R3 remote wake", pulses - base, 1);
    check("R3 source remote", int'(last_src), 0);
    check("R3 rx off", int'(rx_active_o), 0);

    enter_sleep();
    base = pulses;
    bus_pre_i = 1'b1;
    cyc(2 * MON + 20);
    check("R4 rx off on float", int'(rx_active_o), 0);
    check("R4 no wake", pulses - base, 0);
    bus_dom_i = 1'b1; cyc(2 * (BF + 5)); bus_dom_i = 1'b0; cyc(10);
    check("R5 locked", pulses - base, 0);
    check("R5 rx stays off", int'(rx_active_o), 0);
    bus_pre_i = 1'b0; cyc(10);
    remote(BF + 5);
    check("R5 after release", pulses - base, 1);

    enter_sleep();
    base = pulses;
    bus_pre_i = 1'b1; bus_dom_i = 1'b1;
    cyc(2 * MON + 20);
    check("R6 rx off on short", int'(rx_active_o), 0);
    check("R6 no wake while held", pulses - base, 0);
    bus_dom_i = 1'b0; bus_pre_i = 1'b0;
    cyc(8);
    check("R6 wake on release", pulses - base, 1);
    check("R6 source remote", int'(last_src), 0);

    enter_sleep();
    base = pulses;
    local_low(WF - 4);
    check("R7 short low", pulses - base, 0);
    local_low(WF + 4);
    check("R7 local wake", pulses - base, 1);
    check("R7 source local", int'(last_src), 1);
    check("R7 src held", int'(wake_local_o), 1);
    sleep_i = 1'b0; cyc(1);
    check("R10 src cleared", int'(wake_local_o), 0);

    wake_pin_i = 1'b0;
    cyc(10);
    enter_sleep();
    base = pulses;
    cyc(2 * (WF + 20));
    check("R8 stuck low", pulses - base, 0);
    wake_pin_i = 1'b1; cyc(2 * (RA - 3));
    wake_pin_i = 1'b0; cyc(2 * (WF + 10));
    check("R8 short high", pulses - base, 0);
    wake_pin_i = 1'b1; cyc(2 * (RA + 3));
    wake_pin_i = 1'b0; cyc(2 * (WF + 5));
    check("R8 rearmed", pulses - base, 1);
    wake_pin_i = 1'b1; cyc(2 * (RA + 3));

    enter_sleep();
    base = pulses;
    remote(BF + 5);
    local_low(WF + 5);
    remote(BF + 5);
    check("R9 one per sleep", pulses - base, 1);
    check("R9 source kept", int'(wake_local_o), 0);
    check("R9 single cycle", doubles, 0);

    sleep_i = 1'b0;
    cyc(2);
    base = pulses;
    bus_pre_i = 1'b1; cyc(6);
    check("R10 rx awake", int'(rx_active_o), 0);
    bus_dom_i = 1'b1; cyc(2 * (BF + 5)); bus_dom_i = 1'b0; bus_pre_i = 1'b0; cyc(10);
    local_low(WF + 5);
    check("R10 no wake awake", pulses - base, 0);

    for (int i = 0; i < 24; i++) begin
      int kind, dur, exp;
      kind = int'($urandom % 2);
      if (kind == 0)
        dur = ($urandom % 2) ? BF + 4 + int'($urandom % 10) : 1 + int'($urandom % (BF - 5));
      else
        dur = ($urandom % 2) ? WF + 4 + int'($urandom % 8) : 1 + int'($urandom % (WF - 4));
      enter_sleep();
      base = pulses;
      if (kind == 0) begin
        remote(dur);
        exp = exp_wake(dur, BF);
        check("R3 random remote", pulses - base, exp);
        if (exp == 1) check("R3 random source", int'(last_src), 0);
      end else begin
        local_low(dur);
        exp = exp_wake(dur, WF);
        check("R7 random local", pulses - base, exp);
        if (exp == 1) check("R7 random source", int'(last_src), 1);
      end
    end
    check("R9 no double pulse", doubles, 0);

    done = 1'b1;
    report();
  end
endmodule